// File: doc/BRIEF.md
# Memory-Mapped Event Timer with Comparator Channels

The block is a register-mapped event timer for a chip's system timing. A 64-bit main counter advances by one on every clock edge while the global run bit is set. Several comparator channels watch that counter. When a channel's comparator equals the counter, the channel latches a sticky status bit. If the channel's interrupt enable is set, the status drives an interrupt line.

Each channel can work in one of two ways. In one-shot mode the comparator is left alone after a match. In periodic mode the channel's stored increment is added to the comparator on every match, so events repeat at a fixed interval. To load a periodic channel, software writes the configuration with the load-sequence bit set. The next comparator-low write then sets the match value, and the write after that sets the increment. A global legacy bit moves channel 0 to a fixed tick line and channel 1 to a fixed clock-interrupt line. Otherwise every channel picks one line of a routed interrupt bus with a field in its own configuration.

The register bus is a plain 32-bit write strobe with a byte address and a combinational read. The register layout is given in the requirements.

Top module: `evt_timer`

## Requirements
- R1: Two read-only registers report fixed values. Address 0x000 holds the capability word: bits [4:0] are NUM_CH-1, bit 8 is legacy capability and bits [31:16] are the periodic-capable mask (bit 16+n for channel n). Address 0x004 returns PERIOD_FS, the tick period in femtoseconds. After reset the counter, the status register and all interrupt outputs are zero.
- R2: Address 0x010 is the global configuration: bit 0 is run and bit 1 is legacy. The counter increments once per clock while run is 1 and holds while run is 0. Writes to 0x0F0 load counter bits [31:0] and writes to 0x0F4 load bits [63:32]; both halves read back at the same addresses.
- R3: Channel n occupies 0x100+0x20*n. Its configuration is at +0x00, with bit 2 interrupt enable, bit 3 periodic, bit 4 periodic capability (read-only), bit 6 load-sequence (reads 0), bit 8 32-bit match and bits [13:9] route. The comparator low and high halves are at +0x08 and +0x0C, and the increment reads at +0x10. With bit 8 set, a match needs only the low 32 bits of the counter and comparator to be equal. With bit 8 clear, all 64 bits must be equal.
- R4: Address 0x020 holds one status bit per channel, bit n for channel n. A running counter that matches sets the bit. The bit stays set until a write of 1 to that bit position clears it.
- R5: A channel with the periodic bit clear keeps its comparator unchanged after a match.
- R6: A channel with the periodic bit set adds its increment to the comparator on every match. In 32-bit mode only the low half is updated.
- R7: After a configuration write with both bit 6 and bit 3 set, on a periodic-capable channel, the next write to +0x08 sets the comparator low half. The write after that sets the increment. Outside this sequence, writes to +0x08 set only the comparator low half.
- R8: On a channel whose PER_CAP bit is 0, writes to the periodic bit are ignored and the bit reads 0.
- R9: Clearing a channel's interrupt enable removes its interrupt output in the next cycle. The comparator value is left unchanged.
- R10: With legacy set, channel 0's active status drives irq_tick and channel 1's drives irq_rtc, and neither reaches irq_line. With legacy clear, irq_tick and irq_rtc are 0.
- R11: Outside the legacy assignment, an active channel (status and enable both set) drives irq_line[route].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_tick | output | 1 | Legacy tick interrupt (channel 0) |
| irq_rtc | output | 1 | Legacy clock interrupt (channel 1) |
| irq_line | output | NUM_LINES | Routed interrupt lines |

## Verification
The bench uses the default build: three channels, eight routed lines, and channel 1 without periodic support. This one build covers the capability mask with a hole in it, the ignored periodic bit, and both legacy channels next to a routed third channel. Matches are located to the exact counter value, including three consecutive periodic reloads. The counter's high half is preset to 1 so that the 32-bit and 64-bit match rules give opposite results on the same comparator.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int NUM_CH = 3,
  parameter int NUM_LINES = 8,
  parameter logic [31:0] PERIOD_FS = 32'd69841279,
  parameter logic [NUM_CH-1:0] PER_CAP = 3'b101,
  parameter bit LEG_CAP = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 irq_tick,
  output logic                 irq_rtc,
  output logic [NUM_LINES-1:0] irq_line
);
  localparam logic [11:0] A_ID = 12'h000, A_PER = 12'h004, A_GCFG = 12'h010,
                          A_STAT = 12'h020, A_CLO = 12'h0F0, A_CHI = 12'h0F4,
                          A_CH0 = 12'h100;
  localparam int CH_END = 256 + NUM_CH * 32;

  logic [63:0]       cnt;
  logic              run, legacy;
  logic [63:0]       cmp   [NUM_CH];
  logic [31:0]       per   [NUM_CH];
  logic [4:0]        route [NUM_CH];
  logic [1:0]        seq   [NUM_CH];
  logic [NUM_CH-1:0] ie, pm, m32, stat, hit, act;

  wire       ch_sel = (int'(bus_addr) >= 256) && (int'(bus_addr) < CH_END);
  wire [6:0] ch_idx = 7'((bus_addr - A_CH0) >> 5);
  wire [4:0] off    = bus_addr[4:0];

  always_comb
    for (int i = 0; i < NUM_CH; i++)
      hit[i] = run && (m32[i] ? (cnt[31:0] == cmp[i][31:0]) : (cnt == cmp[i]));

  assign act = stat & ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; run <= 1'b0; legacy <= 1'b0;
      ie <= '0; pm <= '0; m32 <= '0; stat <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        cmp[i] <= '0; per[i] <= '0; route[i] <= '0; seq[i] <= 2'd0;
      end
    end else begin
      if (bus_wr && bus_addr == A_GCFG) begin
        run    <= bus_wdata[0];
        legacy <= bus_wdata[1] & LEG_CAP;
      end
      if (bus_wr && bus_addr == A_CLO)      cnt[31:0]  <= bus_wdata;
      else if (bus_wr && bus_addr == A_CHI) cnt[63:32] <= bus_wdata;
      else if (run)                         cnt        <= cnt + 64'd1;

      for (int i = 0; i < NUM_CH; i++) begin
        if (hit[i])
          stat[i] <= 1'b1;
        else if (bus_wr && bus_addr == A_STAT && bus_wdata[i])
          stat[i] <= 1'b0;

        if (hit[i] && pm[i]) begin
          if (m32[i]) cmp[i][31:0] <= cmp[i][31:0] + per[i];
          else        cmp[i]       <= cmp[i] + {32'd0, per[i]};
        end

        if (bus_wr && ch_sel && ch_idx == 7'(i)) begin
          if (off == 5'h00) begin
            ie[i]    <= bus_wdata[2];
            pm[i]    <= bus_wdata[3] & PER_CAP[i];
            m32[i]   <= bus_wdata[8];
            route[i] <= bus_wdata[13:9];
            seq[i]   <= (bus_wdata[6] && bus_wdata[3] && PER_CAP[i]) ? 2'd1 : 2'd0;
          end else if (off == 5'h08) begin
            if (seq[i] == 2'd2) begin
              per[i] <= bus_wdata;
              seq[i] <= 2'd0;
            end else begin
              cmp[i][31:0] <= bus_wdata;
              if (seq[i] == 2'd1) seq[i] <= 2'd2;
            end
          end else if (off == 5'h0C) begin
            cmp[i][63:32] <= bus_wdata;
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ID:   bus_rdata = {16'(PER_CAP), 7'd0, LEG_CAP, 3'd0, 5'(NUM_CH - 1)};
      A_PER:  bus_rdata = PERIOD_FS;
      A_GCFG: bus_rdata = {30'd0, legacy, run};
      A_STAT: bus_rdata = 32'(stat);
      A_CLO:  bus_rdata = cnt[31:0];
      A_CHI:  bus_rdata = cnt[63:32];
      default:
        for (int i = 0; i < NUM_CH; i++)
          if (ch_sel && ch_idx == 7'(i))
            case (off)
              5'h00: bus_rdata = {18'd0, route[i], m32[i], 3'd0, PER_CAP[i], pm[i], ie[i], 2'd0};
              5'h08: bus_rdata = cmp[i][31:0];
              5'h0C: bus_rdata = cmp[i][63:32];
              5'h10: bus_rdata = per[i];
              default: bus_rdata = '0;
            endcase
    endcase
  end

  assign irq_tick = legacy & act[0];
  assign irq_rtc  = legacy & act[1];

  always_comb begin
    irq_line = '0;
    for (int l = 0; l < NUM_LINES; l++)
      for (int i = 0; i < NUM_CH; i++)
        if (act[i] && !(legacy && i < 2) && route[i] == 5'(l))
          irq_line[l] = 1'b1;
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int NUM_CH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [11:0]       bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              run,
  input logic              legacy,
  input logic [63:0]       cnt,
  input logic [63:0]       cmp [NUM_CH],
  input logic [31:0]       per [NUM_CH],
  input logic [NUM_CH-1:0] pm,
  input logic [NUM_CH-1:0] m32,
  input logic [NUM_CH-1:0] stat,
  input logic              irq_tick,
  input logic              irq_rtc
);
  wire cnt_wr = bus_wr && (bus_addr == 12'h0F0 || bus_addr == 12'h0F4);

  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> cnt == $past(cnt));

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> cnt == $past(cnt) + 64'd1);

  p_legacy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy |-> (!irq_tick && !irq_rtc));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_status_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[i] && !(bus_wr && bus_addr == 12'h020 && bus_wdata[i])) |=> stat[i]);

    p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pm[i] && !bus_wr) |=> cmp[i] == $past(cmp[i]));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pm[i] && run && !bus_wr &&
       (m32[i] ? (cnt[31:0] == cmp[i][31:0]) : (cnt == cmp[i])))
      |=> cmp[i][31:0] == $past(cmp[i][31:0] + per[i]));
  end
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .run(run), .legacy(legacy), .cnt(cnt), .cmp(cmp),
  .per(per), .pm(pm), .m32(m32), .stat(stat), .irq_tick(irq_tick),
  .irq_rtc(irq_rtc)
);

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        irq_tick, irq_rtc;
  logic [7:0]  irq_line;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_tick(irq_tick),
    .irq_rtc(irq_rtc), .irq_line(irq_line));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a0, b0;
    logic [31:0] hits [3];
    int nh;
    cyc(3); rst_n = 1'b1; cyc(1);

    // R1: identity, period and reset state
    rd(12'h000, d); chk("R1 id", d, 32'h0005_0102);
    rd(12'h004, d); chk("R1 period", d, 32'd69841279);
    rd(12'h020, d); chk("R1 status", d, 0);
    chk("R1 irq", {irq_tick, irq_rtc, irq_line}, 0);

    // R2: counter hold, load, run
    cyc(5); rd(12'h0F0, d); chk("R2 hold", d, 0);
    wr(12'h0F0, 32'd100); wr(12'h0F4, 32'd7);
    rd(12'h0F0, d); chk("R2 lo", d, 100);
    rd(12'h0F4, d); chk("R2 hi", d, 7);
    wr(12'h010, 32'h1);
    rd(12'h0F0, a0); cyc(10); rd(12'h0F0, b0);
    chk("R2 step", b0 - a0, 10);

    // R5, R11: one-shot on ch0 routed to line 2
    wr(12'h010, 0); wr(12'h0F0, 0); wr(12'h0F4, 0);
    wr(12'h100, 32'h4 | (2 << 9)); wr(12'h108, 32'd20); wr(12'h10C, 0);
    wr(12'h020, 32'h7);
    wr(12'h010, 32'h1);
    for (int k = 0; k < 40; k++) begin
      rd(12'h0F0, d);
      if (d == 20) break;
      cyc(1);
    end
    rd(12'h020, d); chk("R3 no early match", d[0], 0);
    cyc(1);
    rd(12'h020, d); chk("R3 match at cmp", d[0], 1);
    chk("R11 route line2", irq_line, 8'h04);
    rd(12'h108, d); chk("R5 cmp kept", d, 20);

    // R9: disable interrupt
    wr(12'h100, 32'h0 | (2 << 9));
    chk("R9 irq off", irq_line, 0);
    rd(12'h108, d); chk("R9 cmp intact", d, 20);
    rd(12'h020, d); chk("R4 sticky", d[0], 1);
    wr(12'h020, 32'h1);
    rd(12'h020, d); chk("R4 w1c", d[0], 0);

    // R6, R7: periodic load sequence on ch0
    wr(12'h010, 0); wr(12'h0F0, 0); wr(12'h0F4, 0);
    wr(12'h100, 32'h4C); wr(12'h108, 32'd20); wr(12'h108, 32'd7);
    rd(12'h108, d); chk("R7 cmp", d, 20);
    rd(12'h110, d); chk("R7 increment", d, 7);
    wr(12'h020, 32'h7);
    wr(12'h010, 32'h1);
    nh = 0;
    for (int k = 0; k < 80 && nh < 3; k++) begin
      rd(12'h020, d);
      if (d[0]) begin
        rd(12'h0F0, d); hits[nh] = d - 1; nh++;
        wr(12'h020, 32'h1);
      end else cyc(1);
    end
    chk("R6 match1", hits[0], 20);
    chk("R6 match2", hits[1], 27);
    chk("R6 match3", hits[2], 34);
    rd(12'h108, d); chk("R6 cmp advanced", d, 41);

    // R8: ch1 lacks periodic support
    wr(12'h120, 32'h48);
    rd(12'h120, d); chk("R8 ch1 periodic bits", d[4:3], 0);
    rd(12'h100, d); chk("R8 ch0 cap bit", d[4], 1);

    // R3: 32-bit vs 64-bit match on ch2
    wr(12'h100, 0);
    wr(12'h010, 0); wr(12'h0F0, 0); wr(12'h0F4, 1);
    wr(12'h140, 32'h4 | 32'h100 | (3 << 9)); wr(12'h148, 32'd10); wr(12'h14C, 0);
    wr(12'h020, 32'h7); wr(12'h010, 32'h1);
    cyc(15);
    rd(12'h020, d); chk("R3 m32 match", d[2], 1);
    chk("R11 line3", irq_line[3], 1);
    wr(12'h010, 0); wr(12'h020, 32'h7); wr(12'h0F0, 0); wr(12'h0F4, 1);
    wr(12'h140, 32'h4 | (3 << 9)); wr(12'h010, 32'h1);
    cyc(15);
    rd(12'h020, d); chk("R3 m64 no match", d[2], 0);
    chk("R3 m64 line3", irq_line[3], 0);

    // R10: legacy routing
    wr(12'h010, 0); wr(12'h140, 0); wr(12'h020, 32'h7);
    wr(12'h0F0, 0); wr(12'h0F4, 0);
    wr(12'h100, 32'h4); wr(12'h108, 32'd5); wr(12'h10C, 0);
    wr(12'h120, 32'h4); wr(12'h128, 32'd5); wr(12'h12C, 0);
    wr(12'h010, 32'h3);
    cyc(10);
    chk("R10 tick", irq_tick, 1);
    chk("R10 rtc", irq_rtc, 1);
    chk("R10 lines quiet", irq_line, 0);
    wr(12'h010, 32'h1);
    chk("R10 legacy off", {irq_tick, irq_rtc}, 0);
    chk("R11 line0", irq_line, 8'h01);
    wr(12'h100, 0); wr(12'h120, 0);
    chk("R9 all off", irq_line, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule